// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address Filter

This block receives asynchronous serial frames on a line that several slave devices share. The line rests high. A frame opens with a low start bit, carries its data least-significant bit first, and closes with a high stop bit. The 8-bit mode carries eight data bits. The two 9-bit modes carry a ninth bit after the byte. The line is oversampled by a tick that runs at sixteen times the bit rate. Each bit is decided by a majority of three samples around its centre.

When the address filter is on, the block separates address frames from data frames. In the 9-bit modes, the ninth bit marks an address frame. In the 8-bit mode, a valid stop bit takes that role. An address frame raises the receive flag only when the byte matches one of two patterns. The first is the device's masked address. The second is a broadcast pattern built from the address and the mask. All other frames are discarded silently. Software can then turn the filter off, and every later frame raises the flag, so the selected slave takes in its data bytes.

The receive flag is the interrupt request. It stays set until the clear input is pulsed. While it is set, a new frame is dropped and the byte already held is kept.

Top module: `mdrop_rx`

## Requirements
- R1: With `filt_en` low, every frame sets `rx_done`, loads `rx_data` with the byte (first bit received goes to bit 0), and loads `rx_bit9`. In modes 2 and 3 (`mode_sel` 2'd2 and 2'd3) `rx_bit9` takes the ninth bit. In mode 1 (`mode_sel` 2'd1) it takes the sampled stop bit.
- R2: With `mode_sel` 2'd0 nothing is received: `rx_done` stays low whatever `filt_en` is.
- R3: With `filt_en` high in mode 2 or 3, a frame whose ninth bit is 0 leaves `rx_done` low.
- R4: With `filt_en` high, a frame whose ninth bit is 1 is accepted when `(byte ^ dev_addr) & addr_mask` is zero. It is then stored with `rx_bit9` = 1. A frame matching neither address pattern is dropped.
- R5: With `addr_mask` = 8'hFF, only `byte == dev_addr` matches the device address. Any other byte is dropped unless it matches the broadcast pattern.
- R6: With `filt_en` high, a frame is also accepted when the byte has a 1 in every bit position where `dev_addr | addr_mask` has a 1.
- R7: In mode 1 with `filt_en` high, a matching byte is accepted only if its stop bit samples 1. With a stop bit of 0 the frame is dropped.
- R8: A start bit whose three centre samples vote high is a false start. The receiver returns to idle and receives the next frame correctly.
- R9: While `rx_done` is set, a newly completed frame is dropped and `rx_data`/`rx_bit9` keep their values. A `done_clr` pulse clears `rx_done`.
- R10: After reset, `rx_done`, `rx_bit9` and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial line, idle high |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| mode_sel | input | 2 | 0 off, 1 eight-bit, 2/3 nine-bit |
| filt_en | input | 1 | Address filter enable |
| dev_addr | input | 8 | Device address |
| addr_mask | input | 8 | Address mask, 0 bits are don't care |
| done_clr | input | 1 | Clears the receive flag |
| rx_data | output | 8 | Held received byte |
| rx_bit9 | output | 1 | Held ninth bit (stop bit in mode 1) |
| rx_done | output | 1 | Receive flag / interrupt request |

## Verification
The hardest case to reach is a frame that completes while the flag is still held. The bench monitor normally clears the flag as soon as it sees it, so that case never arises on its own. To reach it, the bench switches off its automatic clear. It sends one accepted frame and then a second one. It checks that the held byte survived, and only then pulses the clear. False starts are made by pulling the line low for a fraction of a bit and releasing it before the centre samples are taken.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
  localparam int ADDR_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rx_state_e;

  localparam logic [1:0] MODE_OFF = 2'd0;
  localparam logic [1:0] MODE_8B  = 2'd1;

  // masked individual address: care bits must agree
  function automatic logic given_hit(addr_t b, addr_t a, addr_t m);
    return ((b ^ a) & m) == '0;
  endfunction

  // broadcast: every 1 of (a|m) must be 1 in the byte
  function automatic logic bcast_hit(addr_t b, addr_t a, addr_t m);
    addr_t pat;
    pat = a | m;
    return (b & pat) == pat;
  endfunction
endpackage

// File: rtl/mdrop_addr_match.sv
module mdrop_addr_match
  import mdrop_pkg::*;
(
  input  addr_t rx_byte,
  input  addr_t dev_addr,
  input  addr_t addr_mask,
  output logic  m_given,
  output logic  m_bcast,
  output logic  m_hit
);
  assign m_given = given_hit(rx_byte, dev_addr, addr_mask);
  assign m_bcast = bcast_hit(rx_byte, dev_addr, addr_mask);
  assign m_hit   = m_given | m_bcast;
endmodule

// File: rtl/mdrop_bit_engine.sv
module mdrop_bit_engine
  import mdrop_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_line,
  input  logic          tick,
  input  logic          run,
  input  logic          nine_en,
  output logic          frm_done,
  output logic [DW-1:0] frm_data,
  output logic          frm_ninth,
  output logic          start_abort
);
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DW + 1);
  localparam logic [CW-1:0] S_A   = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] S_B   = CW'(OVS/2);
  localparam logic [CW-1:0] S_C   = CW'(OVS/2 + 1);
  localparam logic [CW-1:0] S_END = CW'(OVS - 1);
  localparam logic [IW-1:0] LAST8 = IW'(DW - 1);
  localparam logic [IW-1:0] LAST9 = IW'(DW);

  logic          line_s1, line_s2, line_prev;
  logic          fall;
  rx_state_e     state;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [1:0]    smp;
  logic [DW:0]   bits;
  logic          nine_q;
  logic          vote, at_mid, at_end;
  logic [IW-1:0] last_idx;

  assign fall     = line_prev & ~line_s2;
  assign vote     = (smp[0] & smp[1]) | (smp[0] & line_s2) | (smp[1] & line_s2);
  assign at_mid   = tick && (cnt == S_C);
  assign at_end   = tick && (cnt == S_END);
  assign last_idx = nine_q ? LAST9 : LAST8;

  assign frm_done    = (state == ST_STOP) && at_mid;
  assign frm_data    = bits[DW-1:0];
  assign frm_ninth   = nine_q ? bits[DW] : vote;
  assign start_abort = (state == ST_START) && at_mid && vote;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_s1   <= 1'b1;
      line_s2   <= 1'b1;
      line_prev <= 1'b1;
    end else begin
      line_s1   <= rx_line;
      line_s2   <= line_s1;
      line_prev <= line_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      idx    <= '0;
      smp    <= '0;
      bits   <= '0;
      nine_q <= 1'b0;
    end else if (!run) begin
      state <= ST_IDLE;
    end else if (state == ST_IDLE) begin
      if (fall) begin
        state  <= ST_START;
        cnt    <= '0;
        idx    <= '0;
        bits   <= '0;
        nine_q <= nine_en;
      end
    end else begin
      if (tick) begin
        cnt <= (cnt == S_END) ? '0 : cnt + 1'b1;
        if (cnt == S_A) smp[0] <= line_s2;
        if (cnt == S_B) smp[1] <= line_s2;
      end
      case (state)
        ST_START: begin
          if (at_mid && vote) state <= ST_IDLE;
          else if (at_end)    state <= ST_DATA;
        end
        ST_DATA: begin
          if (at_mid) bits[idx] <= vote;
          if (at_end) begin
            if (idx == last_idx) state <= ST_STOP;
            else                 idx   <= idx + 1'b1;
          end
        end
        ST_STOP: begin
          if (at_mid) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_abort && run |=> state == ST_IDLE); // R8
  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (state == ST_IDLE) && !frm_done); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |=> !frm_done); // R1
endmodule

// File: rtl/mdrop_rx.sv
module mdrop_rx
  import mdrop_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_line,
  input  logic          tick16,
  input  logic [1:0]    mode_sel,
  input  logic          filt_en,
  input  logic [DW-1:0] dev_addr,
  input  logic [DW-1:0] addr_mask,
  input  logic          done_clr,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit9,
  output logic          rx_done
);
  logic          run, nine_mode;
  logic          frm_done, frm_ninth, start_abort;
  logic [DW-1:0] frm_data;
  logic          m_given, m_bcast, m_hit;
  logic          frame_ok, accept;

  assign run       = (mode_sel != MODE_OFF);
  assign nine_mode = mode_sel[1];

  mdrop_bit_engine #(.OVS(OVS), .DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick(tick16),
    .run(run), .nine_en(nine_mode),
    .frm_done(frm_done), .frm_data(frm_data), .frm_ninth(frm_ninth),
    .start_abort(start_abort)
  );

  mdrop_addr_match u_match (
    .rx_byte(frm_data), .dev_addr(dev_addr), .addr_mask(addr_mask),
    .m_given(m_given), .m_bcast(m_bcast), .m_hit(m_hit)
  );

  assign frame_ok = !filt_en || (frm_ninth && m_hit);
  assign accept   = frm_done && frame_ok && !rx_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_bit9 <= 1'b0;
      rx_done <= 1'b0;
    end else if (accept) begin
      rx_data <= frm_data;
      rx_bit9 <= frm_ninth;
      rx_done <= 1'b1;
    end else if (done_clr) begin
      rx_done <= 1'b0;
    end
  end

  AST_DATA_FRAME_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done && filt_en && nine_mode && !frm_ninth |=> !$rose(rx_done)); // R3
  AST_NO_HIT_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done && filt_en && !m_given && !m_bcast |=> !$rose(rx_done)); // R4
  AST_EXACT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done && (addr_mask == '1) && m_given |-> frm_data == dev_addr); // R5
  AST_BAD_STOP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done && filt_en && !nine_mode && !frm_ninth |=> !$rose(rx_done)); // R7
  AST_HELD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !done_clr |=> $stable(rx_data) && $stable(rx_bit9) && rx_done); // R9
  AST_FLAG_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> $past(frm_done)); // R1
endmodule

// File: tb/sim_mdrop_rx.sv
module sim_mdrop_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       tick16 = 1'b0;
  logic [1:0] mode_sel = 2'd2;
  logic       filt_en = 1'b0;
  logic [7:0] dev_addr = 8'h00;
  logic [7:0] addr_mask = 8'h00;
  logic       clr_mon = 1'b0, clr_man = 1'b0;
  logic       done_clr;
  logic [7:0] rx_data;
  logic       rx_bit9, rx_done;

  int nchk = 0, nbad = 0;
  bit auto_clr = 1'b1;
  bit finished = 1'b0;
  logic [8:0] expq[$];
  logic [1:0] tcnt = 2'd0;

  assign done_clr = clr_mon | clr_man;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tcnt   <= tcnt + 2'd1;
    tick16 <= (tcnt == 2'd3);
  end

  mdrop_rx u0 (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick16(tick16),
    .mode_sel(mode_sel), .filt_en(filt_en), .dev_addr(dev_addr),
    .addr_mask(addr_mask), .done_clr(done_clr),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_done(rx_done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench-side model of the acceptance rule
  function automatic bit want(input logic [7:0] b, input logic n9);
    bit g, bc;
    if (mode_sel == 2'd0) return 1'b0;
    if (!filt_en) return 1'b1;
    if (!n9) return 1'b0;
    g = 1'b1; bc = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (addr_mask[i] && (b[i] != dev_addr[i])) g = 1'b0;
      if ((dev_addr[i] | addr_mask[i]) && !b[i]) bc = 1'b0;
    end
    return g || bc;
  endfunction

  task automatic put_bit(input logic v);
    @(negedge clk);
    rx_line = v;
    repeat (64) @(negedge clk);
  endtask

  task automatic drive_frame(input logic [7:0] b, input logic n9);
    put_bit(1'b0);
    for (int i = 0; i < 8; i++) put_bit(b[i]);
    if (mode_sel != 2'd1) begin
      put_bit(n9);
      put_bit(1'b1);
    end else begin
      put_bit(n9);
    end
    rx_line = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic n9, input string tag);
    if (want(b, n9)) expq.push_back({n9, b});
    drive_frame(b, n9);
    chk(expq.size() == 0, tag, expq.size(), 0);
    expq.delete();
  endtask

  // monitor: pops and compares each raised flag, then clears it
  initial forever begin
    @(negedge clk);
    if (clr_mon) clr_mon = 1'b0;
    else if (auto_clr && rst_n && rx_done) begin
      if (expq.size() == 0) begin
        chk(1'b0, "spurious rx_done (R2/R3/R4/R5/R7)", {23'd0, rx_bit9, rx_data}, 0);
      end else begin
        logic [8:0] e;
        e = expq.pop_front();
        chk({rx_bit9, rx_data} == e, "received frame R1/R4/R6", {23'd0, rx_bit9, rx_data}, {23'd0, e});
      end
      clr_mon = 1'b1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nbad++; nchk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R10 reset state
    chk(rx_done == 1'b0, "R10 rx_done", rx_done, 0);
    chk(rx_data == 8'h00, "R10 rx_data", rx_data, 0);
    chk(rx_bit9 == 1'b0, "R10 rx_bit9", rx_bit9, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1 filter off, all modes
    mode_sel = 2'd2; send(8'hA5, 1'b0, "R1 mode2 data");
    mode_sel = 2'd3; send(8'h3C, 1'b1, "R1 mode3 ninth set");
    mode_sel = 2'd1; send(8'h5A, 1'b1, "R1 mode1 stop high");
    send(8'hC3, 1'b0, "R1 mode1 stop low unfiltered");

    // R2 mode 0 receives nothing, filter or not
    mode_sel = 2'd0; send(8'h77, 1'b1, "R2 mode0 filter off");
    filt_en = 1'b1; send(8'h56, 1'b1, "R2 mode0 filter on");

    // filtered 9-bit mode, addr 56 mask FC
    mode_sel = 2'd2; dev_addr = 8'h56; addr_mask = 8'hFC;
    send(8'h55, 1'b0, "R3 data frame dropped");
    send(8'h55, 1'b1, "R4 masked match 55");
    send(8'h57, 1'b1, "R4 masked match 57");
    send(8'h58, 1'b1, "R4 mismatch dropped");
    send(8'hFF, 1'b1, "R6 broadcast FF");
    send(8'hFE, 1'b1, "R6 broadcast FE");
    mode_sel = 2'd3;
    send(8'hFE, 1'b0, "R3 broadcast byte as data dropped");

    // R5 exact mask
    addr_mask = 8'hFF;
    send(8'h56, 1'b1, "R5 exact hit");
    send(8'h57, 1'b1, "R5 near miss dropped");

    // R7 mode 1 filtered
    mode_sel = 2'd1; addr_mask = 8'hFC;
    send(8'h55, 1'b1, "R7 match good stop");
    send(8'h55, 1'b0, "R7 match bad stop dropped");
    send(8'h58, 1'b1, "R7 mismatch dropped");

    // R8 false start then a good frame
    filt_en = 1'b0; mode_sel = 2'd2;
    @(negedge clk); rx_line = 1'b0;
    repeat (12) @(negedge clk); rx_line = 1'b1;
    repeat (200) @(negedge clk);
    chk(rx_done == 1'b0, "R8 no flag after glitch", rx_done, 0);
    send(8'h96, 1'b1, "R8 frame after false start");

    // R9 held flag blocks new frame
    auto_clr = 1'b0;
    drive_frame(8'h11, 1'b0);
    chk(rx_done == 1'b1, "R9 first frame flag", rx_done, 1);
    chk(rx_data == 8'h11, "R9 first frame data", rx_data, 8'h11);
    drive_frame(8'h22, 1'b1);
    chk(rx_data == 8'h11, "R9 held data kept", rx_data, 8'h11);
    chk(rx_bit9 == 1'b0, "R9 held bit9 kept", rx_bit9, 0);
    chk(rx_done == 1'b1, "R9 flag still set", rx_done, 1);
    @(negedge clk); clr_man = 1'b1;
    @(negedge clk); clr_man = 1'b0;
    @(negedge clk);
    chk(rx_done == 1'b0, "R9 clear drops flag", rx_done, 0);
    auto_clr = 1'b1;
    send(8'h33, 1'b1, "R9 reception resumes");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule